// File: doc/BRIEF.md
# Four-Way Adaptive Intersection Signal Controller

This block drives the signal heads of a four-road junction. Each road (North, East, South, West) has a red, an amber and a green lamp, plus a pedestrian walk output. Only one road at a time is released. It receives a green phase and then an amber phase, while the other three roads show red. Service then passes to the next road in a fixed rotation.

A single traffic-density input selects how long a green lasts. When the input is low, the controller uses the short green. When it is high, it uses the long green. The amber length is the same in both cases. The input is read only on the clock edge that opens a green phase, so a phase never changes length once it has begun.

After a synchronous reset, the junction rests in an all-red state before North gets its first green.

Top module: `tsig_ctrl`

## Requirements
- R1: While `rst` is high, every road shows red and no walk output is set. After `rst` falls, the all-red state lasts `YEL_CYC` cycles, counted from the first cycle in which `rst` is low.
- R2: Greens are granted in the order North (bit 0), East (bit 1), South (bit 2), West (bit 3), and the order then wraps back to North. The first green after reset goes to North.
- R3: During a road's green phase, only that road's green lamp is lit and the other three roads show red. No walk output is set.
- R4: During a road's amber phase, only that road's amber lamp is lit and the other roads show red. That road's walk bit is set, and no other walk bit is set.
- R5: A green phase that opens with `heavy_traffic` = 0 lasts `GRN_LIGHT` cycles (default 8).
- R6: A green phase that opens with `heavy_traffic` = 1 lasts `GRN_HEAVY` cycles (default 16).
- R7: Every amber phase lasts `YEL_CYC` cycles (default 3), whatever the value of `heavy_traffic`.
- R8: `heavy_traffic` is sampled only on the edge that opens a green phase. Changes at any other time do not alter the current green length or the following amber length.
- R9: In every cycle, each road has exactly one lamp lit, and at most one road is not red.
- R10: Raising `rst` in the middle of a phase returns all roads to red on the next edge. The sequence then restarts from the all-red state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| heavy_traffic | input | 1 | 1 = congested, which selects the long green |
| red_o | output | 4 | Red lamps, one bit per road: bit 0 North, 1 East, 2 South, 3 West |
| amber_o | output | 4 | Amber lamps, same bit order |
| green_o | output | 4 | Green lamps, same bit order |
| walk_o | output | 4 | Pedestrian walk outputs, same bit order |

## Verification
The road advance at the end of an amber phase and the density sample for the next green happen on the same clock edge. The bench sets `heavy_traffic` to a scheduled value just before every green-opening edge, and toggles it pseudo-randomly in every other cycle. The lengths of each green and the amber that follows it are then judged against the scheduled value alone. A second collision, a reset raised while a phase timer is still running, is provoked in the middle of a South green. The bench judges it by the immediate all-red state and a fresh North-first restart.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

    localparam int ROADS = 4;

    typedef enum logic [1:0] {
        RD_NORTH = 2'b00,
        RD_EAST  = 2'b01,
        RD_SOUTH = 2'b10,
        RD_WEST  = 2'b11
    } road_e;

    typedef enum logic {
        STEP_GO   = 1'b0,
        STEP_WARN = 1'b1
    } step_e;

    // started = 0 means the post-reset all-red rest
    typedef struct packed {
        logic  started;
        road_e road;
        step_e step;
    } phase_t;

    typedef struct packed {
        logic red;
        logic amber;
        logic green;
    } lamp_t;

    function automatic road_e next_road(input road_e r);
        return road_e'(r + 2'd1);
    endfunction

    function automatic phase_t next_phase(input phase_t p);
        phase_t n;
        if (!p.started) begin
            n.started = 1'b1;
            n.road    = RD_NORTH;
            n.step    = STEP_GO;
        end else if (p.step == STEP_GO) begin
            n.started = 1'b1;
            n.road    = p.road;
            n.step    = STEP_WARN;
        end else begin
            n.started = 1'b1;
            n.road    = next_road(p.road);
            n.step    = STEP_GO;
        end
        return n;
    endfunction

    function automatic lamp_t lamp_for(input phase_t p, input road_e me);
        lamp_t l;
        l.red   = 1'b1;
        l.amber = 1'b0;
        l.green = 1'b0;
        if (p.started && p.road == me) begin
            l.red   = 1'b0;
            l.green = (p.step == STEP_GO);
            l.amber = (p.step == STEP_WARN);
        end
        return l;
    endfunction

endpackage

// File: rtl/tsig_dwell_timer.sv
module tsig_dwell_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rst_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= rst_val;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/tsig_phase_seq.sv
module tsig_phase_seq
    import tsig_pkg::*;
#(
    parameter int GRN_LIGHT = 8,
    parameter int GRN_HEAVY = 16,
    parameter int YEL_CYC   = 3,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             heavy,
    input  logic             expire,
    output phase_t           phase,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] rst_val
);
    localparam logic [CNT_W-1:0] GL_M1 = CNT_W'(GRN_LIGHT - 1);
    localparam logic [CNT_W-1:0] GH_M1 = CNT_W'(GRN_HEAVY - 1);
    localparam logic [CNT_W-1:0] YC_M1 = CNT_W'(YEL_CYC - 1);

    phase_t ph_q;
    phase_t ph_nx;

    assign ph_nx   = next_phase(ph_q);
    assign load    = expire;
    assign rst_val = YC_M1;

    // the density input matters only when a green is about to open
    always_comb begin
        if (ph_nx.step == STEP_GO) begin
            load_val = heavy ? GH_M1 : GL_M1;
        end else begin
            load_val = YC_M1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q.started <= 1'b0;
            ph_q.road    <= RD_NORTH;
            ph_q.step    <= STEP_WARN;
        end else if (expire) begin
            ph_q <= ph_nx;
        end
    end

    assign phase = ph_q;
endmodule

// File: rtl/tsig_lamp_decode.sv
module tsig_lamp_decode
    import tsig_pkg::*;
(
    input  phase_t           phase,
    output logic [ROADS-1:0] red,
    output logic [ROADS-1:0] amber,
    output logic [ROADS-1:0] green,
    output logic [ROADS-1:0] walk
);
    for (genvar i = 0; i < ROADS; i++) begin : g_road
        lamp_t l;
        assign l        = lamp_for(phase, road_e'(i));
        assign red[i]   = l.red;
        assign amber[i] = l.amber;
        assign green[i] = l.green;
        assign walk[i]  = phase.started && phase.step == STEP_WARN && phase.road == road_e'(i);
    end
endmodule

// File: rtl/tsig_ctrl.sv
module tsig_ctrl
    import tsig_pkg::*;
#(
    parameter int GRN_LIGHT = 8,
    parameter int GRN_HEAVY = 16,
    parameter int YEL_CYC   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       heavy_traffic,
    output logic [3:0] red_o,
    output logic [3:0] amber_o,
    output logic [3:0] green_o,
    output logic [3:0] walk_o
);
    localparam int MAX_A = (GRN_LIGHT > GRN_HEAVY) ? GRN_LIGHT : GRN_HEAVY;
    localparam int MAX_D = (MAX_A > YEL_CYC) ? MAX_A : YEL_CYC;
    localparam int CNT_W = $clog2(MAX_D + 1);

    phase_t           phase;
    logic             load;
    logic             expire;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] rst_val;

    tsig_phase_seq #(
        .GRN_LIGHT(GRN_LIGHT),
        .GRN_HEAVY(GRN_HEAVY),
        .YEL_CYC  (YEL_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .heavy   (heavy_traffic),
        .expire  (expire),
        .phase   (phase),
        .load    (load),
        .load_val(load_val),
        .rst_val (rst_val)
    );

    tsig_dwell_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .rst_val (rst_val),
        .load    (load),
        .load_val(load_val),
        .expire  (expire)
    );

    tsig_lamp_decode u_dec (
        .phase(phase),
        .red  (red_o),
        .amber(amber_o),
        .green(green_o),
        .walk (walk_o)
    );
endmodule

// File: rtl/tsig_ctrl_chk.sv
module tsig_ctrl_chk #(
    parameter int YEL_CYC = 3
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] red_o,
    input logic [3:0] amber_o,
    input logic [3:0] green_o,
    input logic [3:0] walk_o
);
    logic [15:0] amb_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            amb_run <= '0;
        end else if (amber_o != '0) begin
            amb_run <= amb_run + 1'b1;
        end else begin
            amb_run <= '0;
        end
    end

    p_reset_dark_r1: assert property (@(posedge clk)
        rst |=> (green_o == 4'h0 && amber_o == 4'h0 && walk_o == 4'h0));

    p_one_lamp_r9: assert property (@(posedge clk) disable iff (rst)
        ((red_o ^ amber_o ^ green_o) == 4'hF) && ((red_o & amber_o) == 4'h0)
        && ((red_o & green_o) == 4'h0) && ((amber_o & green_o) == 4'h0));

    p_single_road_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(amber_o | green_o) <= 1);

    p_walk_amber_r4: assert property (@(posedge clk) disable iff (rst)
        walk_o == amber_o);

    p_order_r2: assert property (@(posedge clk) disable iff (rst)
        (green_o != 4'h0 && $past(amber_o) != 4'h0)
        |-> green_o == {$past(amber_o[2:0]), $past(amber_o[3])});

    p_amber_same_road_r3: assert property (@(posedge clk) disable iff (rst)
        (amber_o != 4'h0 && $past(amber_o) == 4'h0) |-> $past(green_o) == amber_o);

    p_amber_len_r7: assert property (@(posedge clk) disable iff (rst)
        (amber_o == 4'h0 && amb_run != 16'h0) |-> amb_run == 16'(YEL_CYC));
endmodule

bind tsig_ctrl tsig_ctrl_chk #(.YEL_CYC(YEL_CYC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .red_o  (red_o),
    .amber_o(amber_o),
    .green_o(green_o),
    .walk_o (walk_o)
);

// File: tb/tsig_ctrl_tb.sv
module tsig_ctrl_tb;
    localparam int GL = 8;
    localparam int GH = 16;
    localparam int YC = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       heavy;
    logic [3:0] red_o, amber_o, green_o, walk_o;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tsig_ctrl #(.GRN_LIGHT(GL), .GRN_HEAVY(GH), .YEL_CYC(YC)) u_dut (
        .clk(clk), .rst(rst), .heavy_traffic(heavy),
        .red_o(red_o), .amber_o(amber_o), .green_o(green_o), .walk_o(walk_o)
    );

    // expected-state bookkeeping, derived from the requirements
    bit          m_allred;
    int          m_road;
    bit          m_yel;
    int          m_rem;
    bit          m_hv;
    bit          m_first;
    int          gn = 0;
    logic [7:0]  sched = 8'b0110_1001;
    logic [15:0] lfsr  = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_now();
        logic [3:0] nr;
        string tg, tr, tw;
        nr = m_allred ? 4'h0 : (4'b1 << m_road);
        tg = m_allred ? "R1" : (m_yel ? "R7" : (m_hv ? "R6" : "R5"));
        tr = m_allred ? "R1" : (m_yel ? "R4" : "R3");
        tw = m_allred ? "R1" : "R4";
        chk(green_o == ((m_allred || m_yel) ? 4'h0 : nr), tg, "green_o", green_o,
            (m_allred || m_yel) ? 0 : nr);
        chk(amber_o == ((!m_allred && m_yel) ? nr : 4'h0), tg, "amber_o", amber_o,
            (!m_allred && m_yel) ? nr : 0);
        chk(red_o == ~nr, tr, "red_o", red_o, 4'(~nr));
        chk(walk_o == ((!m_allred && m_yel) ? nr : 4'h0), tw, "walk_o", walk_o,
            (!m_allred && m_yel) ? nr : 0);
        for (int i = 0; i < 4; i++) begin
            chk($countones({red_o[i], amber_o[i], green_o[i]}) == 1, "R9", "lamps on road",
                int'({red_o[i], amber_o[i], green_o[i]}), -1);
        end
        chk($countones(amber_o | green_o) <= 1, "R9", "non-red roads", amber_o | green_o, -1);
        if (m_first && !m_allred && !m_yel)
            chk(green_o == nr, "R2", "road granted", green_o, nr);
        if (m_first && !m_allred && m_yel)
            chk(amber_o == nr, "R8", "amber onset after sensor toggles", amber_o, nr);
    endtask

    task automatic step_model();
        if (m_rem == 1) begin
            if (m_allred || m_yel) begin
                m_road   = m_allred ? 0 : (m_road + 1) % 4;
                m_allred = 1'b0;
                m_yel    = 1'b0;
                m_hv     = sched[gn % 8];
                gn++;
                heavy    = m_hv;
                m_rem    = m_hv ? GH : GL;
            end else begin
                m_yel = 1'b1;
                m_rem = YC;
                heavy = lfsr[0];
            end
            m_first = 1'b1;
        end else begin
            m_rem--;
            heavy   = lfsr[0];
            m_first = 1'b0;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic model_release();
        m_allred = 1'b1;
        m_yel    = 1'b0;
        m_road   = 0;
        m_rem    = YC;
        m_first  = 1'b0;
        gn       = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst   = 1'b1;
        heavy = 1'b1;
        m_allred = 1'b1;
        m_yel = 1'b0; m_road = 0; m_rem = YC; m_first = 1'b0; m_hv = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state with sensor high
        repeat (3) begin
            check_now();
            @(negedge clk);
        end
        rst = 1'b0;
        model_release();
        // three-plus rotations with mixed densities (R2..R9)
        repeat (300) begin
            check_now();
            step_model();
            @(negedge clk);
        end
        // R10: reset in the middle of a South green
        while (!(m_road == 2 && !m_allred && !m_yel && m_rem == 5)) begin
            check_now();
            step_model();
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        chk(green_o == 4'h0 && amber_o == 4'h0 && red_o == 4'hF, "R10", "lamps after mid-phase reset",
            {green_o, amber_o, red_o}, 12'h00F);
        chk(walk_o == 4'h0, "R10", "walk after mid-phase reset", walk_o, 0);
        rst = 1'b0;
        model_release();
        repeat (160) begin
            check_now();
            step_model();
            @(negedge clk);
        end
        summary();
    end
endmodule